// File: doc/BRIEF.md
# Dual-Clock Up/Down Binary Counter

This block is a binary counter that is stepped by two separate count inputs. A rising edge on the up input adds one to the count, and a rising edge on the down input subtracts one. The count wraps at both ends. An active-low load input copies a data word into the count. An active-high clear input forces the count to zero, and clear wins over load. Two active-low terminal outputs follow the low phase of the matching count input when the count sits at its end value. The carry output goes low at the all-ones count while the up input is low. The borrow output goes low at zero while the down input is low.

The count inputs are treated as slow asynchronous signals. Each one passes through a synchronizer clocked by a fast system clock, and the block acts on the rising edges it detects there. Clear and load are level overrides that are sampled every system cycle. The terminal outputs rest high and fall only during the low phase of their count input. Because of this they can drive the count inputs of a second instance directly, which builds a wider counter from cascaded stages.

Top module: `updc_counter`

## Requirements
- R1: The count is WIDTH bits of plain binary. Incrementing the all-ones value gives zero, and decrementing zero gives all-ones.
- R2: When the up input changes from low to high, the count increases by one. The change appears at the third rising system clock edge after the input change (two synchronizer stages plus the count register).
- R3: When the down input changes from low to high, the count decreases by one, with the same three-edge latency as R2.
- R4: carry_n is low exactly when the count is all-ones and the synchronized up input is low. At any other time it is high.
- R5: borrow_n is low exactly when the count is zero and the synchronized down input is low. At any other time it is high.
- R6: While load_n is low and clear is low, each system clock edge loads din into the count. A count edge detected while load_n is low is dropped.
- R7: While clear is high, each system clock edge forces the count to zero, whatever load_n and the count inputs are doing.
- R8: If rising edges on both count inputs are detected in the same system cycle, the count does not change.
- R9: When two instances are cascaded, the carry_n and borrow_n of the low stage drive the up and down inputs of the high stage. The pair then counts as one 2*WIDTH-bit counter up through the all-ones value and down through zero.
- R10: While rst_n is low, the count is zero and both terminal outputs are high. Releasing rst_n with both count inputs high produces no count step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all inputs |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clear | input | 1 | Active-high master clear, highest priority |
| load_n | input | 1 | Active-low parallel load |
| din | input | WIDTH | Parallel load data |
| up_clk | input | 1 | Count-up input, acts on its rising edge |
| dn_clk | input | 1 | Count-down input, acts on its rising edge |
| count | output | WIDTH | Current count value |
| carry_n | output | 1 | Active-low terminal count-up (carry) |
| borrow_n | output | 1 | Active-low terminal count-down (borrow) |

## Verification
A change on a count input reaches the count at the third rising system edge after it is applied. A change on load_n or clear reaches the count at the next edge. The terminal outputs follow the synchronized input level in the same cycle that the count register is updated. The bench keeps a behavioural model of two cascaded stages. The model uses integer histories that are two cycles deep, and it advances on every rising edge. The bench drives inputs and compares all outputs on the falling edge, so each expected value is taken in the exact cycle it becomes due. In the cascaded pair, the high stage sees the low stage's terminal pulse through its own synchronizer, and the model applies that extra delay as well.

// File: rtl/updc_pkg.sv
package updc_pkg;

   // Action applied to the count register on a system clock edge
   typedef enum logic [2:0] {
      ACT_HOLD  = 3'd0,
      ACT_INC   = 3'd1,
      ACT_DEC   = 3'd2,
      ACT_LOAD  = 3'd3,
      ACT_CLEAR = 3'd4
   } act_e;

endpackage

// File: rtl/updc_sync_edge.sv
module updc_sync_edge #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic rise
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] chain;
   logic              held;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("updc_sync_edge: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= IDLE;
               else        chain[0] <= raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= IDLE;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= IDLE;
      else        held <= chain[LAST];
   end

   assign level = chain[LAST];
   assign rise  = chain[LAST] & ~held;

   // R2
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/updc_step_sel.sv
module updc_step_sel
   import updc_pkg::*;
(
   input  logic clear,
   input  logic load_n,
   input  logic up_rise,
   input  logic dn_rise,
   output act_e act
);
   // Priority: clear, then load, then counting; both edges together cancel
   always_comb begin
      if (clear)                  act = ACT_CLEAR;
      else if (!load_n)           act = ACT_LOAD;
      else if (up_rise && !dn_rise) act = ACT_INC;
      else if (dn_rise && !up_rise) act = ACT_DEC;
      else                        act = ACT_HOLD;
   end

endmodule

// File: rtl/updc_count_reg.sv
module updc_count_reg
   import updc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  act_e             act,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] count
);
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] ZERO = '0;
   localparam logic [WIDTH-1:0] MAXV = '1;

   logic [WIDTH-1:0] nxt;

   always_comb begin
      unique case (act)
         ACT_CLEAR: nxt = ZERO;
         ACT_LOAD:  nxt = din;
         ACT_INC:   nxt = count + ONE;
         ACT_DEC:   nxt = count - ONE;
         default:   nxt = count;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= ZERO;
      else        count <= nxt;
   end

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_CLEAR) |=> (count == ZERO));

   // R6
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_LOAD) |=> (count == $past(din)));

   // R1
   inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_INC && count == MAXV) |=> (count == ZERO));

   // R1
   dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_DEC && count == ZERO) |=> (count == MAXV));

endmodule

// File: rtl/updc_counter.sv
module updc_counter
   import updc_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   input  logic             up_clk,
   input  logic             dn_clk,
   output logic [WIDTH-1:0] count,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam logic [WIDTH-1:0] MAXV = '1;
   localparam logic [WIDTH-1:0] ZERO = '0;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("updc_counter: WIDTH must be at least 1");
      end
   endgenerate

   logic up_lvl, up_rise, dn_lvl, dn_rise;
   act_e act;

   updc_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_up_sync (
      .clk(clk), .rst_n(rst_n), .raw(up_clk), .level(up_lvl), .rise(up_rise)
   );

   updc_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_dn_sync (
      .clk(clk), .rst_n(rst_n), .raw(dn_clk), .level(dn_lvl), .rise(dn_rise)
   );

   updc_step_sel u_sel (
      .clear(clear), .load_n(load_n), .up_rise(up_rise), .dn_rise(dn_rise),
      .act(act)
   );

   updc_count_reg #(.WIDTH(WIDTH)) u_cnt (
      .clk(clk), .rst_n(rst_n), .act(act), .din(din), .count(count)
   );

   // Terminal pulses: gated by the low phase of the synchronized count input
   assign carry_n  = ~((count == MAXV) & ~up_lvl);
   assign borrow_n = ~((count == ZERO) & ~dn_lvl);

   // R8
   both_edges_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_rise && dn_rise && load_n && !clear) |=> $stable(count));

   // R4
   carry_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(carry_n) && $stable(count) && load_n && !clear && !dn_rise)
      |=> (count == ZERO));

   // R5
   borrow_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(borrow_n) && $stable(count) && load_n && !clear && !up_rise)
      |=> (count == MAXV));

   // R4
   carry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != MAXV) |-> carry_n);

   // R5
   borrow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != ZERO) |-> borrow_n);

endmodule

// File: tb/tb_updc_counter.sv
module tb_updc_counter;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, clear, load_n, up_in, dn_in;
   logic [7:0] din;
   wire  [3:0] cnt_lo, cnt_hi;
   wire        c_lo, b_lo, c_hi, b_hi;

   updc_counter #(.WIDTH(4), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .din(din[3:0]),
      .up_clk(up_in), .dn_clk(dn_in), .count(cnt_lo), .carry_n(c_lo), .borrow_n(b_lo)
   );

   updc_counter #(.WIDTH(4), .SYNC_STAGES(2)) u_hi (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .din(din[7:4]),
      .up_clk(c_lo), .dn_clk(b_lo), .count(cnt_hi), .carry_n(c_hi), .borrow_n(b_hi)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   string tag = "R10";

   // Behavioural model: per stage, two-deep input history plus previous level
   int m_u1[2], m_u2[2], m_up[2], m_d1[2], m_d2[2], m_dp[2], m_cnt[2];

   function automatic int carry_m(int s);
      return (m_cnt[s] == 15 && m_u2[s] == 0) ? 0 : 1;
   endfunction
   function automatic int borrow_m(int s);
      return (m_cnt[s] == 0 && m_d2[s] == 0) ? 0 : 1;
   endfunction

   task automatic model_reset();
      for (int s = 0; s < 2; s++) begin
         m_u1[s] = 1; m_u2[s] = 1; m_up[s] = 1;
         m_d1[s] = 1; m_d2[s] = 1; m_dp[s] = 1; m_cnt[s] = 0;
      end
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         int xu[2], xd[2], ld[2];
         xu[0] = int'(up_in); xd[0] = int'(dn_in);
         xu[1] = carry_m(0);  xd[1] = borrow_m(0);
         ld[0] = int'(din[3:0]); ld[1] = int'(din[7:4]);
         for (int s = 0; s < 2; s++) begin
            bit ru, rd;
            ru = (m_u2[s] == 1 && m_up[s] == 0);
            rd = (m_d2[s] == 1 && m_dp[s] == 0);
            if (clear)            m_cnt[s] = 0;
            else if (!load_n)     m_cnt[s] = ld[s];
            else if (ru && !rd)   m_cnt[s] = (m_cnt[s] + 1) % 16;
            else if (rd && !ru)   m_cnt[s] = (m_cnt[s] + 15) % 16;
            m_up[s] = m_u2[s]; m_u2[s] = m_u1[s]; m_u1[s] = xu[s];
            m_dp[s] = m_d2[s]; m_d2[s] = m_d1[s]; m_d1[s] = xd[s];
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      check(tag, "count", int'({cnt_hi, cnt_lo}), m_cnt[1] * 16 + m_cnt[0]);
      check("R4", "carry_lo",  int'(c_lo), carry_m(0));
      check("R4", "carry_hi",  int'(c_hi), carry_m(1));
      check("R5", "borrow_lo", int'(b_lo), borrow_m(0));
      check("R5", "borrow_hi", int'(b_hi), borrow_m(1));
   end

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         report();
      end
   end

   task automatic waitn(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_up(int n);
      for (int i = 0; i < n; i++) begin
         up_in = 1'b0; waitn(3);
         up_in = 1'b1; waitn(3);
      end
   endtask

   task automatic pulse_dn(int n);
      for (int i = 0; i < n; i++) begin
         dn_in = 1'b0; waitn(3);
         dn_in = 1'b1; waitn(3);
      end
   endtask

   initial begin
      rst_n = 1'b0; clear = 1'b0; load_n = 1'b1; din = 8'h00;
      up_in = 1'b1; dn_in = 1'b1;
      waitn(4);
      check("R10", "reset count", int'({cnt_hi, cnt_lo}), 0);
      check("R10", "reset carry", int'(c_lo), 1);
      rst_n = 1'b1;
      waitn(6);
      check("R10", "no step after release", int'({cnt_hi, cnt_lo}), 0);

      tag = "R9";
      pulse_up(255); waitn(8);
      check("R9", "cascade reaches 255", int'({cnt_hi, cnt_lo}), 255);
      pulse_up(1); waitn(8);
      check("R9", "cascade wraps up", int'({cnt_hi, cnt_lo}), 0);

      tag = "R1";
      pulse_dn(1); waitn(8);
      check("R1", "wrap down from zero", int'({cnt_hi, cnt_lo}), 255);

      tag = "R3";
      pulse_dn(255); waitn(8);
      check("R3", "down to zero", int'({cnt_hi, cnt_lo}), 0);

      tag = "R6";
      din = 8'hFE; load_n = 1'b0; waitn(2); load_n = 1'b1; waitn(4);
      check("R6", "load value", int'({cnt_hi, cnt_lo}), 254);

      tag = "R2";
      pulse_up(3); waitn(8);
      check("R2", "up across 255", int'({cnt_hi, cnt_lo}), 1);

      tag = "R6";
      din = 8'h40; up_in = 1'b0; waitn(3);
      up_in = 1'b1; load_n = 1'b0; waitn(4); load_n = 1'b1; waitn(6);
      check("R6", "edge during load dropped", int'({cnt_hi, cnt_lo}), 64);

      tag = "R7";
      din = 8'h33; load_n = 1'b0; clear = 1'b1; waitn(2);
      clear = 1'b0; load_n = 1'b1; waitn(4);
      check("R7", "clear beats load", int'({cnt_hi, cnt_lo}), 0);

      tag = "R8";
      din = 8'h55; load_n = 1'b0; waitn(1); load_n = 1'b1; waitn(3);
      up_in = 1'b0; dn_in = 1'b0; waitn(3);
      up_in = 1'b1; dn_in = 1'b1; waitn(6);
      check("R8", "both edges hold", int'({cnt_hi, cnt_lo}), 85);

      tag = "R5";
      pulse_dn(6); waitn(8);
      check("R5", "borrow into high stage", int'({cnt_hi, cnt_lo}), 79);

      waitn(4);
      report();
   end

endmodule